// File: doc/BRIEF.md
# Odd-Line Inversion Encoder for Coupling-Aware Link Power

The block sits on the send side of a point-to-point on-chip link that is W lines wide. Each flit offers W-1 payload bits. The remaining line, the top one, carries an inversion flag. For a body flit, the block compares the payload with the encoded flit that was last driven onto the link, one pair of neighbouring lines at a time. It then decides whether complementing every odd-indexed line lowers the coupling cost of the transition. Header flits pass through without change.

The encoded flit is registered and drives the link. A receive-side decoder strips the inversion again, and its output is brought out so that it can be used and checked. The input takes flits through a valid/ready handshake. The link output has its own valid and ready. W must be even and at least 4, so that the flag line is itself an odd-indexed line.

Top module: `link_odd_inv_enc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `link_valid` is 0 and `link_flit` is all zeros.
- R2: An accepted header flit (`in_hdr`=1) appears on `link_flit` as `{1'b0, in_payload}`, with no inversion.
- R3: For lines i and i+1, the coupling cost between the previous line values and the new ones is 1 when exactly one line toggles, 2 when both toggle in opposite directions, and 0 otherwise. A pair votes for inversion only when its cost with the odd lines complemented is strictly lower than its cost without.
- R4: A body flit is inverted exactly when more than (W-1)/2 of the W-1 pairs vote for it. When inverted, bit W-1 of `link_flit` is 1, the odd payload bits (1, 3, 5, ...) are complemented, and the even payload bits are unchanged. When not inverted, the flit is `{1'b0, in_payload}`.
- R5: The previous value that the pairs compare against is the last flit accepted, as it was encoded. This includes header flits. The flag line of the new flit counts as 0 before inversion.
- R6: `dec_payload` equals the payload of the flit currently on `link_flit`. It complements the odd payload bits when bit W-1 is 1.
- R7: For a body flit, the total coupling cost over all pairs of the encoded flit never exceeds that of the unencoded flit `{1'b0, in_payload}`.
- R8: `in_ready` is 0 while `link_valid` is 1 and `link_ready` is 0. During such a stall, `link_flit` and `link_valid` hold.
- R9: An accepted flit is on `link_flit`, with `link_valid` high, one clock after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input flit is offered |
| in_ready | output | 1 | Block can take a flit this cycle |
| in_hdr | input | 1 | Offered flit is a header (bypasses encoding) |
| in_payload | input | W-1 | Payload bits of the offered flit |
| link_valid | output | 1 | Link carries a flit |
| link_ready | input | 1 | Link side takes the flit this cycle |
| link_flit | output | W | Encoded flit; bit W-1 is the inversion flag |
| dec_payload | output | W-1 | Receive-side decoded payload of `link_flit` |

## Verification
The decision logic is combinational on the offered payload and the flit register. The encoded flit is therefore due on `link_flit` one clock after the accepting edge. `dec_payload` follows it within the same cycle. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, which is the first point where the new encoded value, flag and decoded payload are all valid. For each body flit, the expected flag comes from a pair-by-pair vote that the bench computes from its own record of the last flit sent. During the stall test the bench samples at falling edges, so that it sees `in_ready` low and the held flit over several cycles before it releases `link_ready`.

// File: rtl/link_odd_inv_enc.sv
module link_odd_inv_enc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_hdr,
  input  logic [W-2:0] in_payload,
  output logic         link_valid,
  input  logic         link_ready,
  output logic [W-1:0] link_flit,
  output logic [W-2:0] dec_payload
);
  localparam int NP = W - 1;
  localparam int CW = $clog2(W) + 1;

  function automatic logic [W-1:0] odd_lines();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [W-1:0] ODD = odd_lines();

  if (W < 4 || (W % 2) != 0) begin : g_bad_width
    $error("W must be even and at least 4");
  end

  function automatic logic [1:0] pair_cost(input logic [1:0] prv, input logic [1:0] nxt);
    logic [1:0] d;
    d = prv ^ nxt;
    if (d == 2'b01 || d == 2'b10) return 2'd1;
    if (d == 2'b11 && nxt[0] != nxt[1]) return 2'd2;
    return 2'd0;
  endfunction

  logic          take;
  logic [W-1:0]  cur, cand, enc;
  logic [NP-1:0] vote;
  logic [CW-1:0] votes;
  logic          do_inv;

  assign in_ready = !link_valid || link_ready;
  assign take     = in_valid && in_ready;
  assign cur      = {1'b0, in_payload};
  assign cand     = cur ^ ODD;

  for (genvar i = 0; i < NP; i++) begin : g_pair
    logic [1:0] c_raw, c_inv;
    assign c_raw   = pair_cost(link_flit[i+1:i], cur[i+1:i]);
    assign c_inv   = pair_cost(link_flit[i+1:i], cand[i+1:i]);
    assign vote[i] = c_inv < c_raw;
  end

  always_comb begin
    votes = '0;
    for (int i = 0; i < NP; i++) votes = votes + CW'(vote[i]);
  end

  assign do_inv = !in_hdr && ((int'(votes) * 2) > NP);
  assign enc    = do_inv ? cand : cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_flit  <= '0;
      link_valid <= 1'b0;
    end else if (take) begin
      link_flit  <= enc;
      link_valid <= 1'b1;
    end else if (link_ready) begin
      link_valid <= 1'b0;
    end
  end

  assign dec_payload = link_flit[W-2:0] ^ (link_flit[W-1] ? ODD[W-2:0] : '0);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!link_valid && link_flit == '0));

  assert_header_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_hdr) |=> link_flit == {1'b0, $past(in_payload)});

  assert_even_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (link_flit[W-2:0] & ~ODD[W-2:0]) == ($past(in_payload) & ~ODD[W-2:0]));

  assert_roundtrip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (link_valid && dec_payload == $past(in_payload)));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && !link_ready) |=> (link_valid && $stable(link_flit)));
endmodule

// File: tb/link_odd_inv_enc_test.sv
`timescale 1ns/1ps
module link_odd_inv_enc_test;
  localparam int W  = 6;
  localparam int NP = W - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_hdr = 1'b0;
  logic [NP-1:0] in_payload = '0;
  logic          link_ready = 1'b1;
  logic          in_ready, link_valid;
  logic [W-1:0]  link_flit;
  logic [NP-1:0] dec_payload;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] sent = '0;

  always #2 clk = ~clk;

  link_odd_inv_enc #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_payload(in_payload), .link_valid(link_valid),
    .link_ready(link_ready), .link_flit(link_flit), .dec_payload(dec_payload)
  );

  function automatic logic [W-1:0] oddm();
    logic [W-1:0] m = '0;
    for (int i = 1; i < W; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int pcost(input logic a0, input logic a1, input logic b0, input logic b1);
    int t0 = (a0 != b0);
    int t1 = (a1 != b1);
    if (t0 + t1 == 1) return 1;
    if (t0 + t1 == 2 && b0 != b1) return 2;
    return 0;
  endfunction

  function automatic int tcost(input logic [W-1:0] p, input logic [W-1:0] n);
    int s = 0;
    for (int i = 0; i < NP; i++) s += pcost(p[i], p[i+1], n[i], n[i+1]);
    return s;
  endfunction

  function automatic logic [W-1:0] expect_body(input logic [W-1:0] p, input logic [NP-1:0] d);
    logic [W-1:0] raw = {1'b0, d};
    logic [W-1:0] inv = raw ^ oddm();
    int v = 0;
    for (int i = 0; i < NP; i++)
      if (pcost(p[i], p[i+1], inv[i], inv[i+1]) < pcost(p[i], p[i+1], raw[i], raw[i+1])) v++;
    return (2 * v > NP) ? inv : raw;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic hdr, input logic [NP-1:0] d);
    logic [W-1:0] exp;
    int raw_c, enc_c;
    exp = hdr ? {1'b0, d} : expect_body(sent, d);
    raw_c = tcost(sent, {1'b0, d});
    enc_c = tcost(sent, exp);
    @(negedge clk);
    in_valid = 1'b1; in_hdr = hdr; in_payload = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (hdr) check("R2 header", link_flit, exp);
    else     check("R3 R4 R5 body", link_flit, exp);
    check("R9 valid", {{(W-1){1'b0}}, link_valid}, 1);
    check("R6 decode", {1'b0, dec_payload}, {1'b0, d});
    if (!hdr) check("R7 cost", W'(enc_c > raw_c), '0);
    sent = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flit", link_flit, '0);
    check("R1 reset valid", {{(W-1){1'b0}}, link_valid}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {link_valid, link_flit[W-2:0]}, '0);

    for (int a = 0; a < (1 << NP); a++)
      for (int b = 0; b < (1 << NP); b++) begin
        send(1'b1, NP'(a));
        send(1'b0, NP'(b));
      end

    for (int k = 0; k < 600; k++) send(1'b0, NP'($urandom));

    send(1'b0, NP'(5'b10101));
    @(negedge clk);
    link_ready = 1'b0;
    in_valid = 1'b1; in_hdr = 1'b0; in_payload = NP'(5'b01010);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 ready low", {{(W-1){1'b0}}, in_ready}, '0);
      check("R8 flit held", link_flit, sent);
    end
    in_valid = 1'b0;
    link_ready = 1'b1;
    @(negedge clk);
    check("R8 released", {{(W-1){1'b0}}, in_ready}, 1);
    send(1'b0, NP'(5'b01010));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule